// File: doc/BRIEF.md
# Event Readout Framer with Count Header

This block gathers the hit words that belong to one triggered event into a 1024-word local buffer. When the event closes, the block places a 32-bit header in front of the hits. The header tells a bus reader how many hit words follow, and it also carries the event's identity fields. The reader then pulls the header and the hits out one word at a time through a simple read port.

A trigger-accept pulse opens an event and captures its attributes: a 4-bit event ID, a 2-bit level-2 buffer index, a 3-bit scan list code and an 8-bit bunch counter. Hit words then stream in until an end-of-event strobe arrives. The hit count is only known at that point, so the header goes into buffer address 0, which is kept free for it. Hits fill the buffer from address 1 upward.

While the board is busy, the block drives a shared open-drain busy line low. This is modelled as an output-enable that pulls the line low. If a trigger arrives during readout, it is held pending rather than allowed to touch the buffer.

Top module: `evt_framer`

## Requirements
- R1: After reset, `rd_valid_o`, `done_oe_o` and `ovf_o` are all 0, and hit and end-of-event inputs have no effect until a trigger arrives.
- R2: A trigger in idle captures the attributes present on the same cycle, starts collection, and raises `done_oe_o` on the next cycle.
- R3: Hits are stored in arrival order, and each stored hit adds one to the count. When 1023 hits are stored, further hits are dropped, the count holds at 1023, and `ovf_o` goes to 1. `ovf_o` stays at 1 until the next event starts collecting, and then returns to 0.
- R4: When end-of-event is sampled, `done_oe_o` stays 1 and `rd_valid_o` stays 0 for one cycle while the header is written. `rd_valid_o` rises on the cycle after that.
- R5: The header bits are packed as follows. Bit 31 holds event ID bit 0, bit 30 holds ID bit 1, bit 29 holds ID bit 2 and bit 28 holds ID bit 3. Bits 27..26 hold the buffer index and bits 25..23 hold the scan code. Bits 22..18 are zero. Bits 17..10 hold the bunch counter and bits 9..0 hold the hit count.
- R6: When readout begins, `done_oe_o` goes to 0 unless a trigger is pending.
- R7: In readout, `rd_data_o` first shows the header. Each cycle with `rd_en_i` high advances to the next hit, in write order. After the read of the last word, `rd_valid_o` returns to 0.
- R8: A trigger that arrives outside idle is held pending, one deep, with its attributes. It keeps `done_oe_o` at 1 and starts the next collection as soon as the readout ends. Further triggers that arrive while one is already pending are dropped.
- R9: Hit and end-of-event inputs outside collection are ignored, and the buffered data and count stay unchanged.
- R10: A hit that arrives on the same cycle as end-of-event is stored and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger-accept pulse |
| evt_id_i | input | 4 | Event ID, captured at trigger |
| buf_idx_i | input | 2 | Level-2 buffer index, captured at trigger |
| scan_i | input | 3 | Scan list code, captured at trigger |
| bunch_i | input | 8 | Bunch counter value, captured at trigger |
| hit_valid_i | input | 1 | Hit word valid |
| hit_data_i | input | 32 | Hit word |
| eoe_i | input | 1 | End-of-event strobe |
| rd_en_i | input | 1 | Advance read pointer |
| rd_data_o | output | 32 | Current readout word |
| rd_valid_o | output | 1 | Readout word is valid |
| done_oe_o | output | 1 | Pull the shared busy line low |
| ovf_o | output | 1 | Hits were dropped in this event |

## Verification
The bench feeds 1025 hits into one event. It checks that the header count stops at 1023, that the flag is raised, and that the last word read back is hit 1022. A design that wrapped the address would overwrite the header or early hits, and the readback would show it.

Event IDs with a single bit set show whether the ID is mirrored. An unmirrored ID would put bit 0 at bit 28 instead of bit 31.

Triggers are fired in the middle of a readout, a second time while one is already pending, and together with stray hits. A design that restarted at once would damage the event being read. A design that forgot the pending trigger would release the busy line and never collect the next event. Finally, a hit that arrives on the same cycle as end-of-event must show up in the count; an off-by-one there would lose that hit.

// File: rtl/evt_framer_pkg.sv
package evt_framer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COLL = 2'd1,
        ST_HDR  = 2'd2,
        ST_READ = 2'd3
    } fr_state_e;

    typedef struct packed {
        logic [3:0] evt_id;
        logic [1:0] buf_idx;
        logic [2:0] scan;
        logic [7:0] bunch;
    } evt_attr_t;

    localparam int HDR_W = 32;
    localparam int CNT_F = 10;

endpackage

// File: rtl/evt_word_ram.sv
module evt_word_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/evt_hdr_pack.sv
module evt_hdr_pack
    import evt_framer_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  evt_attr_t         attr,
    input  logic [ADDR_W-1:0] cnt,
    output logic [HDR_W-1:0]  hdr
);
    logic [3:0]       id_rev;
    logic [CNT_F-1:0] cnt_f;

    // Event ID is mirrored: ID bit 0 ends up in the top header bit.
    for (genvar g = 0; g < 4; g++) begin : g_rev
        assign id_rev[3-g] = attr.evt_id[g];
    end

    assign cnt_f = CNT_F'(cnt);
    assign hdr   = {id_rev, attr.buf_idx, attr.scan, 5'd0, attr.bunch, cnt_f};

endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
    import evt_framer_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  evt_attr_t         attr_i,
    input  logic              hit_valid_i,
    input  logic              eoe_i,
    input  logic              rd_en_i,
    output fr_state_e         st_o,
    output logic [ADDR_W-1:0] cnt_o,
    output evt_attr_t         cur_o,
    output logic              pend_o,
    output logic              ovf_o,
    output logic              we_o,
    output logic              hdr_sel_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [ADDR_W-1:0] raddr_o
);
    localparam logic [ADDR_W-1:0] MAX_CNT = '1;

    typedef struct packed {
        fr_state_e         st;
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] rptr;
        evt_attr_t         cur;
        evt_attr_t         pnd;
        logic              pend;
        logic              ovf;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d         = q;
        we_o      = 1'b0;
        hdr_sel_o = 1'b0;
        waddr_o   = q.cnt + 1'b1;

        // Trigger while busy: hold one pending, drop the rest.
        if (trig_i && (q.st != ST_IDLE) && !q.pend) begin
            d.pend = 1'b1;
            d.pnd  = attr_i;
        end

        case (q.st)
            ST_IDLE: begin
                if (q.pend) begin
                    d.st   = ST_COLL;
                    d.cur  = q.pnd;
                    d.cnt  = '0;
                    d.ovf  = 1'b0;
                    d.pend = trig_i;
                    d.pnd  = attr_i;
                end else if (trig_i) begin
                    d.st  = ST_COLL;
                    d.cur = attr_i;
                    d.cnt = '0;
                    d.ovf = 1'b0;
                end
            end
            ST_COLL: begin
                if (hit_valid_i) begin
                    if (q.cnt != MAX_CNT) begin
                        we_o  = 1'b1;
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.ovf = 1'b1;
                    end
                end
                if (eoe_i) begin
                    d.st = ST_HDR;
                end
            end
            ST_HDR: begin
                we_o      = 1'b1;
                hdr_sel_o = 1'b1;
                waddr_o   = '0;
                d.st      = ST_READ;
                d.rptr    = '0;
            end
            ST_READ: begin
                if (rd_en_i) begin
                    if (q.rptr == q.cnt) begin
                        if (q.pend) begin
                            d.st   = ST_COLL;
                            d.cur  = q.pnd;
                            d.cnt  = '0;
                            d.ovf  = 1'b0;
                            d.pend = 1'b0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.rptr = q.rptr + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, rptr: '0, cur: '0, pnd: '0,
                   pend: 1'b0, ovf: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign st_o    = q.st;
    assign cnt_o   = q.cnt;
    assign cur_o   = q.cur;
    assign pend_o  = q.pend;
    assign ovf_o   = q.ovf;
    assign raddr_o = q.rptr;

endmodule

// File: rtl/evt_framer.sv
module evt_framer
    import evt_framer_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_i,
    input  logic [3:0]  evt_id_i,
    input  logic [1:0]  buf_idx_i,
    input  logic [2:0]  scan_i,
    input  logic [7:0]  bunch_i,
    input  logic        hit_valid_i,
    input  logic [31:0] hit_data_i,
    input  logic        eoe_i,
    input  logic        rd_en_i,
    output logic [31:0] rd_data_o,
    output logic        rd_valid_o,
    output logic        done_oe_o,
    output logic        ovf_o
);
    evt_attr_t         attr_in;
    evt_attr_t         cur_w;
    fr_state_e         st_w;
    logic [ADDR_W-1:0] cnt_w;
    logic [ADDR_W-1:0] waddr_w;
    logic [ADDR_W-1:0] raddr_w;
    logic              pend_w;
    logic              we_w;
    logic              hdr_sel_w;
    logic [HDR_W-1:0]  hdr_w;
    logic [31:0]       wdata_w;

    assign attr_in = '{evt_id: evt_id_i, buf_idx: buf_idx_i,
                       scan: scan_i, bunch: bunch_i};

    evt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_i),
        .attr_i     (attr_in),
        .hit_valid_i(hit_valid_i),
        .eoe_i      (eoe_i),
        .rd_en_i    (rd_en_i),
        .st_o       (st_w),
        .cnt_o      (cnt_w),
        .cur_o      (cur_w),
        .pend_o     (pend_w),
        .ovf_o      (ovf_o),
        .we_o       (we_w),
        .hdr_sel_o  (hdr_sel_w),
        .waddr_o    (waddr_w),
        .raddr_o    (raddr_w)
    );

    evt_hdr_pack #(.ADDR_W(ADDR_W)) u_hdr (
        .attr(cur_w),
        .cnt (cnt_w),
        .hdr (hdr_w)
    );

    assign wdata_w = hdr_sel_w ? hdr_w : hit_data_i;

    evt_word_ram #(.ADDR_W(ADDR_W), .DATA_W(32)) u_ram (
        .clk  (clk),
        .we   (we_w),
        .waddr(waddr_w),
        .wdata(wdata_w),
        .raddr(raddr_w),
        .rdata(rd_data_o)
    );

    assign rd_valid_o = (st_w == ST_READ);
    assign done_oe_o  = (st_w == ST_COLL) || (st_w == ST_HDR) || pend_w;

endmodule

// File: rtl/evt_framer_chk.sv
module evt_framer_chk
    import evt_framer_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_i,
    input logic              rd_en_i,
    input logic [31:0]       rd_data_o,
    input logic              rd_valid_o,
    input logic              done_oe_o,
    input logic              ovf_o,
    input fr_state_e         st,
    input logic [ADDR_W-1:0] cnt,
    input logic              pend
);
    localparam logic [ADDR_W-1:0] MAX_CNT = '1;

    // R2: any trigger leaves the busy line pulled on the next cycle
    a_r2_trig_holds_busy: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> done_oe_o);

    // R3: a full count never moves until the event is read out
    a_r3_cnt_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COLL && cnt == MAX_CNT) |=> (cnt == MAX_CNT));

    // R3: overflow flag is sticky while collecting
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COLL && ovf_o) |=> ovf_o);

    // R6: busy released at readout start unless a trigger waits
    a_r6_release_at_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_o) |-> (done_oe_o == pend));

    // R7: first readout word is the header carrying the count
    a_r7_header_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_o) |-> (rd_data_o[9:0] == 10'(cnt)));

    // R9: without a read strobe the presented word cannot change
    a_r9_read_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_en_i) |=> (rd_valid_o && $stable(rd_data_o)));

endmodule

bind evt_framer evt_framer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o),
    .done_oe_o (done_oe_o),
    .ovf_o     (ovf_o),
    .st        (st_w),
    .cnt       (cnt_w),
    .pend      (pend_w)
);

// File: tb/tb_evt_framer.sv
`timescale 1ns/1ps
module tb_evt_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_i = 1'b0;
    logic [3:0]  evt_id_i = '0;
    logic [1:0]  buf_idx_i = '0;
    logic [2:0]  scan_i = '0;
    logic [7:0]  bunch_i = '0;
    logic        hit_valid_i = 1'b0;
    logic [31:0] hit_data_i = '0;
    logic        eoe_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        rd_valid_o;
    logic        done_oe_o;
    logic        ovf_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    evt_framer dut (.*);

    typedef struct packed {
        logic [10:0] nhits;
        logic [3:0]  id;
        logic [1:0]  bi;
        logic [2:0]  sc;
        logic [7:0]  bc;
        logic [7:0]  seed;
        logic        merge;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{11'd0,  4'b0001, 2'd0, 3'd0, 8'h00, 8'h11, 1'b0},
        '{11'd1,  4'b1000, 2'd3, 3'd7, 8'hFF, 8'h22, 1'b0},
        '{11'd3,  4'b0110, 2'd1, 3'd5, 8'h5A, 8'h33, 1'b1},
        '{11'd16, 4'b1011, 2'd2, 3'd2, 8'hC3, 8'h44, 1'b0},
        '{11'd40, 4'b0100, 2'd1, 3'd1, 8'h81, 8'h55, 1'b1},
        '{11'd2,  4'b0010, 2'd2, 3'd4, 8'h01, 8'h66, 1'b0}
    };

    function automatic logic [31:0] exp_hdr(logic [3:0] id, logic [1:0] bi,
            logic [2:0] sc, logic [7:0] bc, int cnt);
        logic [9:0] c = 10'(cnt);
        return {id[0], id[1], id[2], id[3], bi, sc, 5'd0, bc, c};
    endfunction

    function automatic logic [31:0] hit_word(logic [7:0] seed, int i);
        logic [15:0] iv = 16'(i);
        return {seed, ~iv[7:0], iv};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_evt(logic [3:0] id, logic [1:0] bi, logic [2:0] sc,
            logic [7:0] bc);
        trig_i = 1'b1; evt_id_i = id; buf_idx_i = bi; scan_i = sc; bunch_i = bc;
        @(negedge clk);
        trig_i = 1'b0; evt_id_i = '0; buf_idx_i = '0; scan_i = '0; bunch_i = '0;
    endtask

    // Ends at the negedge where the block is writing the header.
    task automatic feed(int n, logic [7:0] seed, logic merge);
        for (int i = 0; i < n; i++) begin
            hit_valid_i = 1'b1;
            hit_data_i  = hit_word(seed, i);
            eoe_i       = merge && (i == n - 1);
            @(negedge clk);
        end
        hit_valid_i = 1'b0;
        if (!(merge && n > 0)) begin
            eoe_i = 1'b1;
            @(negedge clk);
        end
        eoe_i = 1'b0;
    endtask

    task automatic readout(int n, logic [7:0] seed, logic [31:0] hdr, logic noise);
        for (int k = 0; k <= n; k++) begin
            chk("R7 read word", rd_data_o, (k == 0) ? hdr : hit_word(seed, k - 1));
            chk("R7 valid during read", 32'(rd_valid_o), 32'd1);
            rd_en_i = 1'b1;
            if (noise) begin
                hit_valid_i = 1'b1; hit_data_i = 32'hDEADBEEF; eoe_i = 1'b1;
            end
            @(negedge clk);
            rd_en_i = 1'b0; hit_valid_i = 1'b0; eoe_i = 1'b0;
        end
        chk("R7 valid drops after last", 32'(rd_valid_o), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] h;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd_valid", 32'(rd_valid_o), 32'd0);
        chk("R1 done_oe", 32'(done_oe_o), 32'd0);
        chk("R1 ovf", 32'(ovf_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R9: hits and end-of-event in idle are ignored
        hit_valid_i = 1'b1; hit_data_i = 32'h12345678; eoe_i = 1'b1;
        repeat (3) @(negedge clk);
        hit_valid_i = 1'b0; eoe_i = 1'b0;
        chk("R1 idle no busy", 32'(done_oe_o), 32'd0);
        chk("R9 idle no readout", 32'(rd_valid_o), 32'd0);

        // Table of events (R2 R4 R5 R6 R7 R10)
        for (int v = 0; v < NV; v++) begin
            start_evt(VECS[v].id, VECS[v].bi, VECS[v].sc, VECS[v].bc);
            chk("R2 busy after trigger", 32'(done_oe_o), 32'd1);
            feed(int'(VECS[v].nhits), VECS[v].seed, VECS[v].merge);
            chk("R4 busy in header cycle", 32'(done_oe_o), 32'd1);
            chk("R4 no valid in header cycle", 32'(rd_valid_o), 32'd0);
            @(negedge clk);
            chk("R6 busy released", 32'(done_oe_o), 32'd0);
            h = exp_hdr(VECS[v].id, VECS[v].bi, VECS[v].sc, VECS[v].bc,
                        int'(VECS[v].nhits));
            chk("R5 R10 header", rd_data_o, h);
            readout(int'(VECS[v].nhits), VECS[v].seed, h, 1'b0);
        end

        // R3: overflow and saturation
        start_evt(4'b1111, 2'd3, 3'd6, 8'hAA);
        feed(1025, 8'h77, 1'b0);
        chk("R3 ovf set", 32'(ovf_o), 32'd1);
        @(negedge clk);
        h = exp_hdr(4'b1111, 2'd3, 3'd6, 8'hAA, 1023);
        chk("R3 header count 1023", rd_data_o, h);
        readout(1023, 8'h77, h, 1'b0);
        start_evt(4'b0011, 2'd0, 3'd3, 8'h10);
        chk("R3 ovf cleared on new event", 32'(ovf_o), 32'd0);
        feed(2, 8'h88, 1'b0);
        @(negedge clk);
        h = exp_hdr(4'b0011, 2'd0, 3'd3, 8'h10, 2);
        readout(2, 8'h88, h, 1'b0);

        // R8/R9: pending trigger during readout, a dropped second trigger
        start_evt(4'b0101, 2'd1, 3'd2, 8'h3C);
        feed(2, 8'h99, 1'b0);
        @(negedge clk);
        h = exp_hdr(4'b0101, 2'd1, 3'd2, 8'h3C, 2);
        start_evt(4'b1001, 2'd2, 3'd4, 8'hE7);
        chk("R8 busy while pending", 32'(done_oe_o), 32'd1);
        chk("R8 header intact", rd_data_o, h);
        start_evt(4'b1110, 2'd3, 3'd7, 8'h42);
        readout(2, 8'h99, h, 1'b1);
        chk("R8 pending starts collection", 32'(done_oe_o), 32'd1);
        feed(1, 8'hAB, 1'b0);
        @(negedge clk);
        h = exp_hdr(4'b1001, 2'd2, 3'd4, 8'hE7, 1);
        chk("R8 R9 pending event header", rd_data_o, h);
        readout(1, 8'hAB, h, 1'b0);
        chk("R8 second trigger dropped", 32'(done_oe_o), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule